// File: doc/BRIEF.md
# SD card SPI-mode block data transfer engine

This block runs the data phase of SD card block reads and writes over an SPI byte channel. A single `start` pulse with a direction, a block count and a block address makes the engine ask an external command framer for the matching read or write command. Once the card accepts that command, the engine moves whole blocks between a byte-wide local buffer port and the card.

On reads it polls for the start token, stores the block bytes and clocks past the two check bytes. On writes it sends the start token, the block bytes and two filler check bytes. It then decodes the card's data-response byte and polls through the busy period. Multi-block runs are closed with a stop-transmission command for reads and with a stop token for writes.

The byte channel carries one exchange at a time. Each byte sent returns one byte received. When the transfer ends, `done_o` pulses for one cycle and `result_o` holds the outcome.

Top module: `sd_blk_xfer`

## Requirements
- R1: On start, the framer is asked for command index 17 (read) or 24 (write) when the block count is 0 or 1, and 18 (read) or 25 (write) otherwise, with the block address as argument. The index and argument stay stable while the request waits for its acknowledge. A nonzero card status byte ends the transfer with result 4 and no byte exchanges.
- R2: Before each read block, every byte sent is 0xFF. The engine keeps polling while the card returns 0xFF, for at most TOKEN_POLLS exchanges. If the first other byte is not 0xFE, or the limit is used up, the transfer ends with result 1.
- R3: After the token, BLK_BYTES read bytes are written to buffer addresses 0 upward, in arrival order, with `buf_blk_o` equal to the block index (starting at 0). The two bytes that follow are clocked in and never written to the buffer.
- R4: In a multi-block read, each block waits for its own token. After the last block the framer is asked for command 12 with argument 0, then a busy wait runs, and the result is 0.
- R5: A write block sends the token 0xFE in single mode or 0xFC in multi mode, then buffer bytes 0 upward of the current block, then 0xFF twice. The buffer write-enable stays low during writes.
- R6: After each written block, one byte is read and its low 5 bits are decoded. 0x05 means accepted. 0x0B ends with result 2. Any other value ends with result 3. A non-accepted block stops further blocks.
- R7: A busy wait sends 0xFF until the card returns a nonzero byte or BUSY_POLLS exchanges have passed, then continues. Reaching the limit does not change the result.
- R8: A multi-block write runs a busy wait after each accepted block. After the last block, or after a rejected block, it sends 0xFD followed by a busy wait. A single-block write runs one busy wait after its response byte.
- R9: `done_o` is high for exactly one cycle per transfer, with `result_o` valid (0 means success). A start while a transfer is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (used only when idle) |
| write_i | input | 1 | 1 = write to card, 0 = read from card |
| blk_cnt_i | input | CNT_W | Number of blocks |
| blk_addr_i | input | 32 | Card block address |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | 0 ok, 1 no start token, 2 check error, 3 write rejected, 4 command rejected |
| cmd_req_o | output | 1 | Command request to framer, held until acknowledge |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_ack_i | input | 1 | Framer finished; status byte valid |
| cmd_r1_i | input | 8 | Card status byte for the command |
| xb_start_o | output | 1 | Start one byte exchange |
| xb_tx_o | output | 8 | Byte to send, valid with xb_start_o |
| xb_done_i | input | 1 | Exchange finished |
| xb_rx_i | input | 8 | Byte received, valid with xb_done_i |
| buf_blk_o | output | CNT_W | Block index within the run |
| buf_addr_o | output | AW | Byte address within the block |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_we_o | output | 1 | Buffer write enable |
| buf_rdata_i | input | 8 | Buffer read data for buf_addr_o (same cycle) |

## Verification
The bench builds the engine with BLK_BYTES=16, TOKEN_POLLS=8, BUSY_POLLS=6 and CNT_W=4. Short blocks make multi-block reads and writes finish in a few hundred cycles. The small poll limits make token starvation and busy-limit exhaustion reachable, so the exact exchange counts at those limits can be checked. A scripted card answers each byte exchange, which lets the bench place wrong tokens, masked response codes and long busy runs at exact byte positions.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_TOKEN, ST_RDATA, ST_RCRC, ST_STOPCMD,
    ST_WTOKEN, ST_WDATA, ST_WCRC, ST_WRESP, ST_STOPTOK, ST_BUSY, ST_DONE
  } sdb_state_e;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_NO_TOKEN = 3'd1,
    RES_CRC      = 3'd2,
    RES_WRITE    = 3'd3,
    RES_CMD      = 3'd4
  } sdb_result_e;

  localparam logic [7:0] BYTE_IDLE  = 8'hFF;
  localparam logic [7:0] TOK_SINGLE = 8'hFE;
  localparam logic [7:0] TOK_MULTI  = 8'hFC;
  localparam logic [7:0] TOK_STOP   = 8'hFD;

  localparam logic [5:0] IDX_RD_ONE  = 6'd17;
  localparam logic [5:0] IDX_RD_MANY = 6'd18;
  localparam logic [5:0] IDX_WR_ONE  = 6'd24;
  localparam logic [5:0] IDX_WR_MANY = 6'd25;
  localparam logic [5:0] IDX_HALT    = 6'd12;

endpackage

// File: rtl/sdb_byte_link.sv
module sdb_byte_link (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       xb_done_i,
  output logic       xb_start_o,
  output logic [7:0] xb_tx_o,
  output logic       got_o
);

  logic       pend_q, pend_d;
  logic       start_q, start_d;
  logic [7:0] tx_q;
  logic       issue;

  always_comb begin
    issue   = go_i & ~pend_q;
    pend_d  = issue | (pend_q & ~xb_done_i);
    start_d = issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else if (issue) tx_q <= tx_i;
  end

  assign xb_start_o = start_q;
  assign xb_tx_o    = tx_q;
  assign got_o      = pend_q & xb_done_i;

endmodule

// File: rtl/sdb_poll_timer.sv
module sdb_poll_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic step_i,
  output logic last_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !run_i || step_i;
    cnt_d  = run_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = run_i && step_i && (cnt_q == CW'(LIMIT - 1));

  // R7: the poll count never passes its limit while polling
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < CW'(LIMIT)));

endmodule

// File: rtl/sdb_resp_decode.sv
module sdb_resp_decode
  import sdb_pkg::*;
(
  input  logic [7:0]  byte_i,
  output logic        accept_o,
  output sdb_result_e code_o
);

  logic [4:0] low5;

  always_comb begin
    low5     = byte_i[4:0];
    accept_o = 1'b0;
    code_o   = RES_WRITE;
    case (low5)
      5'h05: begin accept_o = 1'b1; code_o = RES_OK; end
      5'h0B: code_o = RES_CRC;
      default: code_o = RES_WRITE;
    endcase
  end

endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer
  import sdb_pkg::*;
#(
  parameter int BLK_BYTES   = 512,
  parameter int TOKEN_POLLS = 625000,
  parameter int BUSY_POLLS  = 1562500,
  parameter int CNT_W       = 16,
  localparam int AW         = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic [31:0]      blk_addr_i,
  output logic             done_o,
  output logic [2:0]       result_o,
  output logic             cmd_req_o,
  output logic [5:0]       cmd_idx_o,
  output logic [31:0]      cmd_arg_o,
  input  logic             cmd_ack_i,
  input  logic [7:0]       cmd_r1_i,
  output logic             xb_start_o,
  output logic [7:0]       xb_tx_o,
  input  logic             xb_done_i,
  input  logic [7:0]       xb_rx_i,
  output logic [CNT_W-1:0] buf_blk_o,
  output logic [AW-1:0]    buf_addr_o,
  output logic [7:0]       buf_wdata_o,
  output logic             buf_we_o,
  input  logic [7:0]       buf_rdata_i
);

  sdb_state_e       state_q, state_d, ret_q, ret_d;
  sdb_result_e      res_q, res_d, resp_code;
  logic             write_q, write_d, multi_q, multi_d, crc_q, crc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, blk_q, blk_d;
  logic [31:0]      addr_q, addr_d;
  logic [AW-1:0]    byte_q, byte_d;

  logic       go, got, resp_ok, byte_last, blk_last;
  logic [7:0] tx_next;
  logic [1:0] poll_run, poll_last;

  // byte channel
  always_comb begin
    go = 1'b0;
    case (state_q)
      ST_TOKEN, ST_RDATA, ST_RCRC, ST_WTOKEN, ST_WDATA,
      ST_WCRC, ST_WRESP, ST_STOPTOK, ST_BUSY: go = 1'b1;
      default: go = 1'b0;
    endcase
    case (state_q)
      ST_WTOKEN:  tx_next = multi_q ? TOK_MULTI : TOK_SINGLE;
      ST_WDATA:   tx_next = buf_rdata_i;
      ST_STOPTOK: tx_next = TOK_STOP;
      default:    tx_next = BYTE_IDLE;
    endcase
  end

  sdb_byte_link u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go),
    .tx_i      (tx_next),
    .xb_done_i (xb_done_i),
    .xb_start_o(xb_start_o),
    .xb_tx_o   (xb_tx_o),
    .got_o     (got)
  );

  // poll limits: index 0 start-token wait, index 1 busy wait
  assign poll_run[0] = (state_q == ST_TOKEN);
  assign poll_run[1] = (state_q == ST_BUSY);

  for (genvar g = 0; g < 2; g++) begin : g_poll
    localparam int LIM = (g == 0) ? TOKEN_POLLS : BUSY_POLLS;
    sdb_poll_timer #(.LIMIT(LIM)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (poll_run[g]),
      .step_i(got),
      .last_o(poll_last[g])
    );
  end

  sdb_resp_decode u_dec (
    .byte_i  (xb_rx_i),
    .accept_o(resp_ok),
    .code_o  (resp_code)
  );

  assign byte_last = (byte_q == AW'(BLK_BYTES - 1));
  assign blk_last  = !multi_q || (blk_q == cnt_q - 1'b1);

  // next state
  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    res_d   = res_q;
    write_d = write_q;
    multi_d = multi_q;
    cnt_d   = cnt_q;
    blk_d   = blk_q;
    addr_d  = addr_q;
    byte_d  = byte_q;
    crc_d   = crc_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CMD;
        write_d = write_i;
        multi_d = blk_cnt_i > CNT_W'(1);
        cnt_d   = blk_cnt_i;
        blk_d   = '0;
        addr_d  = blk_addr_i;
        res_d   = RES_OK;
      end
      ST_CMD: if (cmd_ack_i) begin
        if (cmd_r1_i != 8'h00) begin
          res_d   = RES_CMD;
          state_d = ST_DONE;
        end else begin
          byte_d  = '0;
          state_d = write_q ? ST_WTOKEN : ST_TOKEN;
        end
      end
      ST_TOKEN: if (got) begin
        if (xb_rx_i != BYTE_IDLE) begin
          if (xb_rx_i == TOK_SINGLE) begin
            byte_d  = '0;
            state_d = ST_RDATA;
          end else begin
            res_d   = RES_NO_TOKEN;
            state_d = ST_DONE;
          end
        end else if (poll_last[0]) begin
          res_d   = RES_NO_TOKEN;
          state_d = ST_DONE;
        end
      end
      ST_RDATA: if (got) begin
        byte_d = byte_q + 1'b1;
        if (byte_last) begin
          crc_d   = 1'b0;
          state_d = ST_RCRC;
        end
      end
      ST_RCRC: if (got) begin
        crc_d = 1'b1;
        if (crc_q) begin
          if (!blk_last) begin
            blk_d   = blk_q + 1'b1;
            state_d = ST_TOKEN;
          end else if (multi_q) begin
            state_d = ST_STOPCMD;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_STOPCMD: if (cmd_ack_i) begin
        ret_d   = ST_DONE;
        state_d = ST_BUSY;
      end
      ST_WTOKEN: if (got) begin
        byte_d  = '0;
        state_d = ST_WDATA;
      end
      ST_WDATA: if (got) begin
        byte_d = byte_q + 1'b1;
        if (byte_last) begin
          crc_d   = 1'b0;
          state_d = ST_WCRC;
        end
      end
      ST_WCRC: if (got) begin
        crc_d = 1'b1;
        if (crc_q) state_d = ST_WRESP;
      end
      ST_WRESP: if (got) begin
        state_d = ST_BUSY;
        if (resp_ok) begin
          if (!multi_q) ret_d = ST_DONE;
          else if (blk_last) ret_d = ST_STOPTOK;
          else begin
            blk_d = blk_q + 1'b1;
            ret_d = ST_WTOKEN;
          end
        end else begin
          res_d = resp_code;
          if (multi_q) state_d = ST_STOPTOK;
          else ret_d = ST_DONE;
        end
      end
      ST_STOPTOK: if (got) begin
        ret_d   = ST_DONE;
        state_d = ST_BUSY;
      end
      ST_BUSY: if (got && (xb_rx_i != 8'h00 || poll_last[1])) state_d = ret_q;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_DONE;
      res_q   <= RES_OK;
      write_q <= 1'b0;
      multi_q <= 1'b0;
      cnt_q   <= '0;
      blk_q   <= '0;
      addr_q  <= '0;
      byte_q  <= '0;
      crc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      res_q   <= res_d;
      write_q <= write_d;
      multi_q <= multi_d;
      cnt_q   <= cnt_d;
      blk_q   <= blk_d;
      addr_q  <= addr_d;
      byte_q  <= byte_d;
      crc_q   <= crc_d;
    end
  end

  // outputs
  always_comb begin
    cmd_req_o = (state_q == ST_CMD) || (state_q == ST_STOPCMD);
    if (state_q == ST_STOPCMD) begin
      cmd_idx_o = IDX_HALT;
      cmd_arg_o = '0;
    end else begin
      cmd_idx_o = write_q ? (multi_q ? IDX_WR_MANY : IDX_WR_ONE)
                          : (multi_q ? IDX_RD_MANY : IDX_RD_ONE);
      cmd_arg_o = addr_q;
    end
  end

  assign buf_blk_o   = blk_q;
  assign buf_addr_o  = byte_q;
  assign buf_wdata_o = xb_rx_i;
  assign buf_we_o    = (state_q == ST_RDATA) && got;
  assign done_o      = (state_q == ST_DONE);
  assign result_o    = res_q;

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R1: a pending command request keeps its index and argument
  p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && !cmd_ack_i |=> cmd_req_o && $stable(cmd_idx_o) && $stable(cmd_arg_o));

  // R1: no byte exchange starts while a command is with the framer
  p_cmd_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o |-> !xb_start_o);

  // R2: a read transfer only ever sends idle bytes
  p_read_idle_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xb_start_o && !write_q |-> xb_tx_o == BYTE_IDLE);

  // R5: a write transfer never writes the local buffer
  p_no_buf_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    write_q && state_q != ST_IDLE |-> !buf_we_o);

endmodule

// File: tb/sd_blk_xfer_tb.sv
module sd_blk_xfer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BB = 16;
  localparam int TP = 8;
  localparam int BP = 6;
  localparam int CW = 4;
  localparam int AW = $clog2(BB);

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, write_i;
  logic [CW-1:0] blk_cnt_i;
  logic [31:0] blk_addr_i;
  logic done_o;
  logic [2:0] result_o;
  logic cmd_req_o, cmd_ack_i;
  logic [5:0] cmd_idx_o;
  logic [31:0] cmd_arg_o;
  logic [7:0] cmd_r1_i;
  logic xb_start_o, xb_done_i;
  logic [7:0] xb_tx_o, xb_rx_i;
  logic [CW-1:0] buf_blk_o;
  logic [AW-1:0] buf_addr_o;
  logic [7:0] buf_wdata_o, buf_rdata_i;
  logic buf_we_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_blk_xfer #(.BLK_BYTES(BB), .TOKEN_POLLS(TP), .BUSY_POLLS(BP), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
    .blk_cnt_i(blk_cnt_i), .blk_addr_i(blk_addr_i), .done_o(done_o), .result_o(result_o),
    .cmd_req_o(cmd_req_o), .cmd_idx_o(cmd_idx_o), .cmd_arg_o(cmd_arg_o),
    .cmd_ack_i(cmd_ack_i), .cmd_r1_i(cmd_r1_i),
    .xb_start_o(xb_start_o), .xb_tx_o(xb_tx_o), .xb_done_i(xb_done_i), .xb_rx_i(xb_rx_i),
    .buf_blk_o(buf_blk_o), .buf_addr_o(buf_addr_o), .buf_wdata_o(buf_wdata_o),
    .buf_we_o(buf_we_o), .buf_rdata_i(buf_rdata_i)
  );

  int checks = 0;
  int errors = 0;

  // local buffer model
  logic [7:0] rmem [16][16];
  logic [7:0] wmem [16][16];
  int wcount = 0;
  assign buf_rdata_i = rmem[buf_blk_o][buf_addr_o];
  always @(posedge clk) begin
    if (buf_we_o) begin
      wmem[buf_blk_o][buf_addr_o] <= buf_wdata_o;
      wcount <= wcount + 1;
    end
  end

  // scripted card on the byte channel
  logic [7:0] script [256];
  int sc_len = 0;
  logic [7:0] sc_dflt = 8'hFF;
  logic [7:0] tx_log [1024];
  int tx_n = 0;
  int tx_base = 0;

  initial begin
    xb_done_i = 1'b0;
    xb_rx_i = 8'h00;
    forever begin
      @(posedge clk); #1;
      if (xb_start_o) begin
        int k;
        k = tx_n - tx_base;
        tx_log[tx_n % 1024] = xb_tx_o;
        tx_n++;
        @(posedge clk); #1;
        xb_rx_i = (k < sc_len) ? script[k] : sc_dflt;
        xb_done_i = 1'b1;
        @(posedge clk); #1;
        xb_done_i = 1'b0;
      end
    end
  end

  // command framer model
  logic [5:0]  cmd_idx_log [64];
  logic [31:0] cmd_arg_log [64];
  int cmd_n = 0;
  int cmd_base = 0;
  logic [7:0] r1_val = 8'h00;

  initial begin
    cmd_ack_i = 1'b0;
    cmd_r1_i = 8'h00;
    forever begin
      @(posedge clk); #1;
      if (cmd_req_o) begin
        cmd_idx_log[cmd_n % 64] = cmd_idx_o;
        cmd_arg_log[cmd_n % 64] = cmd_arg_o;
        cmd_n++;
        @(posedge clk); #1;
        cmd_r1_i = (cmd_idx_o == 6'd12) ? 8'h00 : r1_val;
        cmd_ack_i = 1'b1;
        @(posedge clk); #1;
        cmd_ack_i = 1'b0;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic sc_reset(input logic [7:0] d);
    sc_len = 0;
    sc_dflt = d;
  endtask

  task automatic sc_add(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      script[sc_len] = b;
      sc_len++;
    end
  endtask

  task automatic launch(input bit wr, input int cnt, input logic [31:0] addr);
    tx_base = tx_n;
    cmd_base = cmd_n;
    @(negedge clk);
    write_i = wr;
    blk_cnt_i = cnt[CW-1:0];
    blk_addr_i = addr;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_xfer(output int res);
    int n;
    n = 0;
    res = -1;
    while (n < 4000) begin
      @(posedge clk); #1;
      if (done_o) begin
        res = int'(result_o);
        break;
      end
      n++;
    end
    @(posedge clk); #1;
    chk("R9 done pulse width one cycle", int'(done_o), 0);
  endtask

  task automatic t_reset;
    chk("R9 reset done low", int'(done_o), 0);
    chk("R9 reset no command", int'(cmd_req_o), 0);
    chk("R9 reset no exchange", int'(xb_start_o), 0);
    chk("R3 reset no buffer write", int'(buf_we_o), 0);
  endtask

  task automatic t_read_single;
    int res, wb;
    sc_reset(8'hFF);
    sc_add(8'hFF, 2); sc_add(8'hFE, 1);
    for (int i = 0; i < BB; i++) sc_add(8'(i * 7 + 3), 1);
    sc_add(8'hAA, 1); sc_add(8'h55, 1);
    r1_val = 8'h00;
    wb = wcount;
    launch(1'b0, 1, 32'h0000_1234);
    finish_xfer(res);
    chk("R1 single read index", int'(cmd_idx_log[cmd_base % 64]), 17);
    chk("R1 single read argument", int'(cmd_arg_log[cmd_base % 64]), 32'h1234);
    chk("R1 single read command count", cmd_n - cmd_base, 1);
    chk("R2 single read result", res, 0);
    chk("R2 single read exchange count", tx_n - tx_base, 3 + BB + 2);
    for (int i = 0; i < tx_n - tx_base; i++)
      chk("R2 read sends idle byte", int'(tx_log[(tx_base + i) % 1024]), 8'hFF);
    for (int i = 0; i < BB; i++)
      chk("R3 single read data", int'(wmem[0][i]), (i * 7 + 3) & 8'hFF);
    chk("R3 check bytes not stored", wcount - wb, BB);
  endtask

  task automatic t_read_multi;
    int res, wb;
    sc_reset(8'h00);
    for (int b = 0; b < 3; b++) begin
      sc_add(8'hFF, 1); sc_add(8'hFE, 1);
      for (int i = 0; i < BB; i++) sc_add(8'(b * 16 + i + 5), 1);
      sc_add(8'h12, 2);
    end
    sc_add(8'h00, 2); sc_add(8'h01, 1);
    r1_val = 8'h00;
    wb = wcount;
    launch(1'b0, 3, 32'h0000_0040);
    finish_xfer(res);
    chk("R1 multi read index", int'(cmd_idx_log[cmd_base % 64]), 18);
    chk("R4 stop command index", int'(cmd_idx_log[(cmd_base + 1) % 64]), 12);
    chk("R4 stop command argument", int'(cmd_arg_log[(cmd_base + 1) % 64]), 0);
    chk("R4 multi read result", res, 0);
    chk("R4 exchanges incl busy wait", tx_n - tx_base, 3 * (2 + BB + 2) + 3);
    chk("R3 multi read stored count", wcount - wb, 3 * BB);
    for (int b = 0; b < 3; b++)
      for (int i = 0; i < BB; i++)
        chk("R3 multi read data per block", int'(wmem[b][i]), (b * 16 + i + 5) & 8'hFF);
  endtask

  task automatic t_read_bad_token;
    int res, wb;
    sc_reset(8'hFF);
    sc_add(8'hFF, 1); sc_add(8'hFC, 1);
    wb = wcount;
    launch(1'b0, 1, 32'h0);
    finish_xfer(res);
    chk("R2 wrong token result", res, 1);
    chk("R2 wrong token exchanges", tx_n - tx_base, 2);
    chk("R3 wrong token no buffer write", wcount - wb, 0);
  endtask

  task automatic t_read_timeout;
    int res;
    sc_reset(8'hFF);
    launch(1'b0, 1, 32'h0);
    finish_xfer(res);
    chk("R2 token wait limit result", res, 1);
    chk("R2 token wait limit exchanges", tx_n - tx_base, TP);
  endtask

  task automatic t_cmd_reject;
    int res;
    sc_reset(8'hFF);
    r1_val = 8'h04;
    launch(1'b0, 1, 32'h77);
    finish_xfer(res);
    chk("R1 rejected command result", res, 4);
    chk("R1 rejected command no exchanges", tx_n - tx_base, 0);
    r1_val = 8'h00;
  endtask

  task automatic t_write_single;
    int res;
    sc_reset(8'h00);
    sc_add(8'hFF, 1 + BB + 2); sc_add(8'hE5, 1);
    sc_add(8'h00, 2); sc_add(8'hFF, 1);
    launch(1'b1, 0, 32'h0000_0099);
    finish_xfer(res);
    chk("R1 count zero write index", int'(cmd_idx_log[cmd_base % 64]), 24);
    chk("R1 write argument", int'(cmd_arg_log[cmd_base % 64]), 32'h99);
    chk("R5 single token", int'(tx_log[tx_base % 1024]), 8'hFE);
    for (int i = 0; i < BB; i++)
      chk("R5 single write data", int'(tx_log[(tx_base + 1 + i) % 1024]), int'(rmem[0][i]));
    chk("R5 first filler byte", int'(tx_log[(tx_base + 1 + BB) % 1024]), 8'hFF);
    chk("R5 second filler byte", int'(tx_log[(tx_base + 2 + BB) % 1024]), 8'hFF);
    chk("R6 masked accept result", res, 0);
    chk("R8 single write exchanges incl busy", tx_n - tx_base, 1 + BB + 2 + 1 + 3);
  endtask

  task automatic t_write_multi;
    int res, p;
    sc_reset(8'h00);
    sc_add(8'hFF, 1 + BB + 2); sc_add(8'h05, 1); sc_add(8'h00, 1); sc_add(8'h01, 1);
    sc_add(8'hFF, 1 + BB + 2); sc_add(8'h05, 1); sc_add(8'h02, 1);
    sc_add(8'hFF, 1); sc_add(8'h00, 1); sc_add(8'h03, 1);
    launch(1'b1, 2, 32'h0000_0200);
    finish_xfer(res);
    p = 1 + BB + 2 + 1 + 2;
    chk("R1 multi write index", int'(cmd_idx_log[cmd_base % 64]), 25);
    chk("R1 multi write one command", cmd_n - cmd_base, 1);
    chk("R5 multi token block 0", int'(tx_log[tx_base % 1024]), 8'hFC);
    chk("R8 busy then token block 1", int'(tx_log[(tx_base + p) % 1024]), 8'hFC);
    for (int i = 0; i < BB; i++)
      chk("R5 multi write data block 1", int'(tx_log[(tx_base + p + 1 + i) % 1024]), int'(rmem[1][i]));
    chk("R8 stop token", int'(tx_log[(tx_base + p + 1 + BB + 2 + 1 + 1) % 1024]), 8'hFD);
    chk("R8 multi write exchanges", tx_n - tx_base, 2 * p + 2);
    chk("R6 multi write result", res, 0);
  endtask

  task automatic t_write_crc_err;
    int res;
    sc_reset(8'h00);
    sc_add(8'hFF, 1 + BB + 2); sc_add(8'hEB, 1); sc_add(8'hFF, 1); sc_add(8'h01, 1);
    launch(1'b1, 3, 32'h0);
    finish_xfer(res);
    chk("R6 check error result", res, 2);
    chk("R8 stop token after reject", int'(tx_log[(tx_base + BB + 4) % 1024]), 8'hFD);
    chk("R6 no further blocks", tx_n - tx_base, 1 + BB + 2 + 1 + 2);
  endtask

  task automatic t_write_err;
    int res;
    sc_reset(8'h00);
    sc_add(8'hFF, 1 + BB + 2); sc_add(8'h0D, 1); sc_add(8'h05, 1);
    launch(1'b1, 1, 32'h0);
    finish_xfer(res);
    chk("R6 write error result", res, 3);
    chk("R8 single reject busy wait", tx_n - tx_base, 1 + BB + 2 + 1 + 1);
  endtask

  task automatic t_busy_limit;
    int res;
    sc_reset(8'h00);
    sc_add(8'hFF, 1 + BB + 2); sc_add(8'h05, 1);
    launch(1'b1, 1, 32'h0);
    finish_xfer(res);
    chk("R7 busy limit exchanges", tx_n - tx_base, 1 + BB + 2 + 1 + BP);
    chk("R7 busy limit keeps result", res, 0);
  endtask

  task automatic t_start_ignored;
    int res;
    sc_reset(8'hFF);
    sc_add(8'hFF, 2); sc_add(8'hFE, 1);
    for (int i = 0; i < BB; i++) sc_add(8'(i + 100), 1);
    sc_add(8'h00, 2);
    launch(1'b0, 1, 32'h55);
    repeat (12) @(negedge clk);
    write_i = 1'b1;
    blk_cnt_i = 4'd3;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    finish_xfer(res);
    chk("R9 second start ignored: one command", cmd_n - cmd_base, 1);
    chk("R9 second start ignored: read index", int'(cmd_idx_log[cmd_base % 64]), 17);
    chk("R9 second start ignored: exchanges", tx_n - tx_base, 3 + BB + 2);
    chk("R9 second start ignored: result", res, 0);
    chk("R9 second start ignored: data", int'(wmem[0][BB-1]), BB - 1 + 100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 16; b++)
      for (int i = 0; i < 16; i++) begin
        rmem[b][i] = 8'((b * 37 + i * 3 + 1) & 8'hFF);
        wmem[b][i] = 8'h00;
      end
    rst_n = 1'b0;
    start_i = 1'b0;
    write_i = 1'b0;
    blk_cnt_i = '0;
    blk_addr_i = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read_single();
    t_read_multi();
    t_read_bad_token();
    t_read_timeout();
    t_cmd_reject();
    t_write_single();
    t_write_multi();
    t_write_crc_err();
    t_write_err();
    t_busy_limit();
    t_start_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule